// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a processor into asynchronous serial frames on a single line. Each frame has a low start bit and eight data bits sent least significant bit first. An optional even or odd parity bit follows the data, and a high stop bit closes the frame. The block keeps two stages. A holding register receives the byte that software writes. A shift register holds the frame on the line. This lets software queue the next byte while the current one is still being sent.

Two flags report progress. The empty flag rises as soon as the pending byte moves into the shift register. The done flag rises when a stop bit finishes and nothing is waiting. The empty flag is checked at the close of every stop bit. If a byte is pending, its start bit follows the stop bit with no idle gap. If nothing is pending, the line rests high and the done flag is raised. Each flag has its own interrupt request line, gated by an enable input. The block does not divide the clock: bit timing comes from an external oversampling tick, with a fixed number of ticks per bit.

Top module: `dbuf_uart_tx`

## Requirements
- R1: A cycle with `wr_i`=1 stores `wdata_i` and clears `empty_o` and `done_o` from the next cycle on. A write made while a byte is still pending replaces that byte, and the replaced byte is never sent.
- R2: When enabled and idle with `empty_o`=0, the block loads the pending byte. In the next cycle `empty_o`=1 and `txd_o`=0 (start bit).
- R3: Every bit of a frame lasts exactly TICKS_PER_BIT (16) cycles with `baud_tick_i`=1. Ticks arriving while the block is idle are ignored.
- R4: The frame order is start bit 0, then data bits D0 to D7 (D0 first), then the optional parity bit, then stop bit 1.
- R5: With `par_en_i`=1 at load time, a parity bit is inserted. Its value is the XOR of D0..D7 when `par_odd_i`=0, and the inverse of that XOR when `par_odd_i`=1. With `par_en_i`=0 no parity bit is sent.
- R6: If `empty_o`=0 on the tick that ends a stop bit, the pending byte is loaded on that tick. `empty_o` becomes 1 and the new start bit begins in the very next cycle.
- R7: If `empty_o`=1 on the tick that ends a stop bit, `done_o` becomes 1 in the next cycle and `txd_o` stays 1.
- R8: With `tx_en_i`=0, `txd_o` is 1, any frame in progress is dropped, and no byte is loaded. Writes are still accepted, and a pending byte is sent once `tx_en_i` returns to 1.
- R9: `irq_empty_o` equals `empty_o` AND `irq_empty_en_i`. `irq_done_o` equals `done_o` AND `irq_done_en_i`. Both are levels.
- R10: After reset `empty_o`=1, `done_o`=1 and `txd_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable |
| par_en_i | input | 1 | Insert parity bit |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| irq_empty_en_i | input | 1 | Enable for the empty interrupt |
| irq_done_en_i | input | 1 | Enable for the done interrupt |
| wr_i | input | 1 | Write strobe for the holding register |
| wdata_i | input | 8 | Byte to send |
| baud_tick_i | input | 1 | Oversampling tick, 16 per bit |
| txd_o | output | 1 | Serial output, idle high |
| empty_o | output | 1 | Holding register empty |
| done_o | output | 1 | Transmission finished, line in mark |
| irq_empty_o | output | 1 | Empty interrupt request |
| irq_done_o | output | 1 | Done interrupt request |

## Verification
A wrong bit counter or a wrong state shows on `txd_o` within one bit time: a bit is too long, a bit is too short, or a bit has the wrong value. A wrong decision at the stop bit shows one cycle after the closing tick. The symptom is either a missing start bit with `done_o` raised, or a spurious start bit. A flag update that is lost or misordered shows on `empty_o` or `done_o` in the cycle after the write or the load. The bench compares every output against its model on every clock, so each of these faults is caught in the cycle it appears.

// File: rtl/dbuf_uart_tx_pkg.sv
package dbuf_uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/dbuf_tx_regs.sv
module dbuf_tx_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_i,
  input  logic              end_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              done_o
);
  logic [DATA_W-1:0] data_q;
  logic              empty_q, done_q;

  // a write wins over a same-cycle load or end event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      empty_q <= 1'b1;
      done_q  <= 1'b1;
    end else if (wr_i) begin
      data_q  <= wdata_i;
      empty_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (load_i) empty_q <= 1'b1;
      if (end_i)  done_q  <= 1'b1;
    end
  end

  assign data_o  = data_q;
  assign empty_o = empty_q;
  assign done_o  = done_q;
endmodule

// File: rtl/dbuf_tx_bitclk.sv
module dbuf_tx_bitclk #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic bit_end_o
);
  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (tick_i) begin
      if (cnt_q == LAST)    cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_end_o = run_i && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/dbuf_tx_frame.sv
module dbuf_tx_frame
  import dbuf_uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              bit_end_i,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              run_o,
  output logic              load_o,
  output logic              end_o,
  output logic              txd_o
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic              par_bit_q, par_en_q;
  logic              line;

  assign load_o = tx_en_i && !empty_i &&
                  ((state_q == ST_IDLE) || (state_q == ST_STOP && bit_end_i));
  assign end_o  = tx_en_i && (state_q == ST_STOP) && bit_end_i && empty_i;
  assign run_o  = tx_en_i && (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      shreg_q   <= '0;
      idx_q     <= '0;
      par_bit_q <= 1'b0;
      par_en_q  <= 1'b0;
    end else if (!tx_en_i) begin
      state_q <= ST_IDLE;
    end else if (load_o) begin
      state_q   <= ST_START;
      shreg_q   <= data_i;
      par_bit_q <= (^data_i) ^ par_odd_i;
      par_en_q  <= par_en_i;
    end else if (bit_end_i) begin
      unique case (state_q)
        ST_START: begin
          state_q <= ST_DATA;
          idx_q   <= '0;
        end
        ST_DATA: begin
          shreg_q <= shreg_q >> 1;
          if (idx_q == LAST_IDX) state_q <= par_en_q ? ST_PAR : ST_STOP;
          else                   idx_q   <= idx_q + 1'b1;
        end
        ST_PAR:  state_q <= ST_STOP;
        ST_STOP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg_q[0];
      ST_PAR:   line = par_bit_q;
      default:  line = 1'b1;
    endcase
  end

  assign txd_o = !tx_en_i || line;
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              irq_empty_en_i,
  input  logic              irq_done_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              baud_tick_i,
  output logic              txd_o,
  output logic              empty_o,
  output logic              done_o,
  output logic              irq_empty_o,
  output logic              irq_done_o
);
  logic [DATA_W-1:0] hold_data;
  logic              load, frame_end, run, bit_end;

  dbuf_tx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .load_i  (load),
    .end_i   (frame_end),
    .data_o  (hold_data),
    .empty_o (empty_o),
    .done_o  (done_o)
  );

  dbuf_tx_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_bitclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .tick_i    (baud_tick_i),
    .bit_end_o (bit_end)
  );

  dbuf_tx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_en_i   (tx_en_i),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .bit_end_i (bit_end),
    .empty_i   (empty_o),
    .data_i    (hold_data),
    .run_o     (run),
    .load_o    (load),
    .end_o     (frame_end),
    .txd_o     (txd_o)
  );

  assign irq_empty_o = empty_o && irq_empty_en_i;
  assign irq_done_o  = done_o && irq_done_en_i;
endmodule

// File: rtl/dbuf_uart_tx_chk.sv
module dbuf_uart_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic wr_i,
  input logic txd_o,
  input logic empty_o,
  input logic done_o,
  input logic irq_done_o
);
  p_empty_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(empty_o) |-> $past(wr_i));

  p_write_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (!empty_o && !done_o));

  p_load_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(empty_o) |-> $past(tx_en_i));

  p_done_mark_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> txd_o);

  p_done_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (empty_o && $past(tx_en_i)));

  p_irq_done_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |-> done_o);
endmodule

bind dbuf_uart_tx dbuf_uart_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_en_i    (tx_en_i),
  .wr_i       (wr_i),
  .txd_o      (txd_o),
  .empty_o    (empty_o),
  .done_o     (done_o),
  .irq_done_o (irq_done_o)
);

// File: tb/dbuf_uart_tx_bench.sv
module dbuf_uart_tx_bench;
  localparam int CLK_P = 10;
  localparam int TPB   = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic       ie_empty = 1'b0, ie_done = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       tick = 1'b0;
  logic       txd, empty, done, irq_e, irq_d;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  int tick_div = 2, tick_ph = 0;
  bit finished = 0;

  // reference model state
  logic       m_empty = 1'b1, m_done = 1'b1, m_act = 1'b0;
  logic [7:0] m_data = '0;
  int         m_cnt = 0;
  logic       m_bits[$];

  dbuf_uart_tx u_dbuf_uart_tx (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en), .par_en_i(par_en),
    .par_odd_i(par_odd), .irq_empty_en_i(ie_empty), .irq_done_en_i(ie_done),
    .wr_i(wr), .wdata_i(wdata), .baud_tick_i(tick), .txd_o(txd),
    .empty_o(empty), .done_o(done), .irq_empty_o(irq_e), .irq_done_o(irq_d)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    #2;
    if (tick_div <= 0) tick = 1'b0;
    else begin
      tick_ph++;
      tick = (tick_ph % tick_div) == 0;
    end
  end

  task automatic chk(string req, string nm, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, nm, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // R4/R5 frame built from the requirements
  function automatic void build(logic [7:0] d);
    m_bits.delete();
    m_bits.push_back(1'b0);
    for (int i = 0; i < 8; i++) m_bits.push_back(d[i]);
    if (par_en) m_bits.push_back((^d) ^ par_odd);
    m_bits.push_back(1'b1);
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_empty = 1'b1; m_done = 1'b1; m_act = 1'b0; m_cnt = 0; m_data = '0;
      m_bits.delete();
    end else begin
      if (!tx_en) begin
        m_act = 1'b0; m_cnt = 0; m_bits.delete();          // R8
      end else if (!m_act) begin
        if (!m_empty) begin                                  // R2
          build(m_data); m_act = 1'b1; m_cnt = 0; m_empty = 1'b1;
        end
      end else if (tick) begin                               // R3
        m_cnt++;
        if (m_cnt == TPB) begin
          m_cnt = 0;
          void'(m_bits.pop_front());
          if (m_bits.size() == 0) begin
            if (!m_empty) begin build(m_data); m_empty = 1'b1; end  // R6
            else begin m_act = 1'b0; m_done = 1'b1; end             // R7
          end
        end
      end
      if (wr) begin m_data = wdata; m_empty = 1'b0; m_done = 1'b0; end  // R1
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_ni) begin
      chk("R4", "txd", txd, (!tx_en) ? 1'b1 : (m_act ? m_bits[0] : 1'b1));
      chk("R1", "empty", empty, m_empty);
      chk("R7", "done", done, m_done);
      chk("R9", "irq_empty", irq_e, m_empty & ie_empty);
      chk("R9", "irq_done", irq_d, m_done & ie_done);
    end
    if (cycles > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic do_write(logic [7:0] b);
    step(); wr = 1'b1; wdata = b;
    step(); wr = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      step();
      if (done) return;
    end
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 20000; i++) begin
      step();
      if (empty) return;
    end
  endtask

  initial begin
    // R10 reset values
    idle(2);
    @(negedge clk);
    chk("R10", "txd", txd, 1'b1);
    chk("R10", "empty", empty, 1'b1);
    chk("R10", "done", done, 1'b1);
    step(); rst_ni = 1'b1;
    idle(3);

    // R3 ticks while idle are ignored; R4 plain frame
    tx_en = 1'b1; ie_empty = 1'b1;
    idle(40);
    do_write(8'hA5);
    wait_done();
    idle(10);

    // R5 even then odd parity
    par_en = 1'b1; par_odd = 1'b0; ie_done = 1'b1;
    do_write(8'h3C);
    wait_done();
    par_odd = 1'b1;
    do_write(8'h01);
    wait_done();
    do_write(8'hFF);
    wait_done();
    par_en = 1'b0;

    // R6 chained frames with one tick per cycle
    tick_div = 1;
    do_write(8'h81);
    wait_empty();
    do_write(8'h7E);
    wait_empty();
    do_write(8'h00);
    wait_done();

    // R1 overwrite of a pending byte
    tick_div = 3; ie_empty = 1'b0;
    do_write(8'h11);
    idle(3);
    do_write(8'h22);
    do_write(8'h33);
    wait_done();
    wait_done();

    // R8 disable mid-frame, write while disabled, resume
    tick_div = 2;
    do_write(8'h5A);
    idle(100);
    tx_en = 1'b0;
    idle(20);
    do_write(8'h77);
    idle(20);
    tx_en = 1'b1;
    wait_done();
    idle(5);

    // R9 enables toggled while flags steady
    ie_done = 1'b0; ie_empty = 1'b1;
    idle(5);
    ie_done = 1'b1; ie_empty = 1'b0;
    idle(5);
    finish_run();
  end
endmodule